// File: doc/BRIEF.md
# Two-Operand Addressing Mode Decoder with Constant Generator

This block turns the operand-mode fields of a two-operand instruction into the controls that the execution stages need. It takes the source register number with its 2-bit mode and the destination register number with its 1-bit mode. It reports the operand kind and whether the source needs a memory read. It flags when an extension word must be fetched and when the source register must be stepped after the access, and by how much. It also gives the write enables for the destination and whether the low address bit has to be dropped for a word access.

The instruction set has only four basic modes: register, indexed, indirect and indirect with post-increment. Immediate, absolute and symbolic operands are not separate modes. Each one is a basic mode applied to a special register. Post-increment on the program counter (register 0) gives an immediate. Indexed on register 0 gives a symbolic operand. Indexed on register 2 gives an absolute address, because register 2 reads as zero in that mode. Register 2 in its two indirect modes, and register 3 in every mode, do not name storage. The decoder turns these combinations into small constants, so they need neither a memory read nor an extension word. Writes to register 3 are dropped without any error.

The results are registered, so each decode appears one clock after its fields are presented. Every field combination gives a defined result, and no combination raises an exception.

Top module: `opmode_decoder`

## Requirements
- R1: While rst_n is low, every output is held at zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge, so a new field set may be presented every cycle.
- R3: src_kind repeats the source mode encoding (0 register, 1 indexed, 2 indirect, 3 post-increment), and dst_kind repeats the destination mode (0 register, 1 indexed).
- R4: const_vld is high, and const_val carries the constant, for these cases only: register 2 in mode 2 gives 4, register 2 in mode 3 gives 8, and register 3 in modes 0, 1, 2 and 3 gives 0, 1, 2 and all ones. In every other case const_val is 0.
- R5: src_mem_rd is high for source modes 1, 2 and 3 unless the combination is a constant from R4.
- R6: src_ext is high for mode 1 on any register except 3, and for mode 3 on register 0. src_imm marks register 0 in mode 3, src_sym marks register 0 in mode 1, and src_abs marks register 2 in mode 1 (base reads as zero).
- R7: inc_we is high for source mode 3 except on registers 2 and 3. inc_amt is then 2 for register 0 or for a word operand (byte_op low), and 1 for a byte operand. inc_amt is 0 whenever inc_we is low.
- R8: With dst_mode 1 and any destination register except 3, dst_mem_wr and dst_ext are high. With dst_mode 0 and any register except 3, dst_reg_we is high; this includes register 2, which holds the status word. Destination register 3 raises none of the three.
- R9: addr_lsb_clr is high for a word operand (byte_op low) whenever src_mem_rd or dst_mem_wr is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_reg | input | 4 | Source register number |
| src_mode | input | 2 | Source addressing mode |
| dst_reg | input | 4 | Destination register number |
| dst_mode | input | 1 | Destination addressing mode |
| byte_op | input | 1 | High for a byte-sized operation |
| src_kind | output | 2 | Source operand kind |
| src_mem_rd | output | 1 | Source needs a memory read |
| src_ext | output | 1 | Source needs an extension word |
| src_imm | output | 1 | Source is an immediate |
| src_sym | output | 1 | Source is symbolic (PC relative) |
| src_abs | output | 1 | Source is absolute (zero base) |
| const_vld | output | 1 | Source is a generated constant |
| const_val | output | 16 | Generated constant value |
| dst_kind | output | 1 | Destination operand kind |
| dst_mem_wr | output | 1 | Destination is written to memory |
| dst_ext | output | 1 | Destination needs an extension word |
| dst_reg_we | output | 1 | Destination register write enable |
| inc_we | output | 1 | Source register post-increment enable |
| inc_amt | output | 2 | Post-increment step |
| addr_lsb_clr | output | 1 | Drop address bit 0 for a word access |

## Verification
Every output is due at the first rising edge after its fields are driven, so each decode is checked exactly one cycle after its stimulus. The driver changes the fields on a falling edge and pushes the expected decode into a queue at the same moment. The monitor wakes shortly after each rising edge and pops one entry per cycle. Fields change on every cycle, so a decode that lags by a cycle, or that leaks from a neighbouring cycle, meets a different expected entry and is reported.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

  localparam int RIDX_W = 4;

  localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(0);
  localparam logic [RIDX_W-1:0] SR_IDX = RIDX_W'(2);
  localparam logic [RIDX_W-1:0] CG_IDX = RIDX_W'(3);

  typedef enum logic [1:0] {
    MODE_REG  = 2'd0,
    MODE_IDX  = 2'd1,
    MODE_IND  = 2'd2,
    MODE_AINC = 2'd3
  } amode_e;

  // Register and mode select a generated constant rather than storage.
  function automatic logic fn_is_const(input logic [RIDX_W-1:0] r, input amode_e m);
    logic hit;
    hit = 1'b0;
    if (r == CG_IDX) hit = 1'b1;
    else if (r == SR_IDX && (m == MODE_IND || m == MODE_AINC)) hit = 1'b1;
    return hit;
  endfunction

  // Post-increment step: the program counter always moves a full word.
  function automatic logic [1:0] fn_step(input logic is_pc, input logic is_byte);
    return (is_pc || !is_byte) ? 2'd2 : 2'd1;
  endfunction

  // Extension word needed by the source field.
  function automatic logic fn_src_ext(input logic [RIDX_W-1:0] r, input amode_e m);
    return (m == MODE_IDX && r != CG_IDX) || (m == MODE_AINC && r == PC_IDX);
  endfunction

endpackage

// File: rtl/opmode_cg.sv
module opmode_cg
  import opmode_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [RIDX_W-1:0] reg_num,
  input  amode_e            mode,
  output logic              hit,
  output logic [DATA_W-1:0] value
);

  logic [DATA_W-1:0] sr_const;
  logic [DATA_W-1:0] cg_const;

  always_comb begin
    sr_const = '0;
    unique case (mode)
      MODE_IND:  sr_const = DATA_W'(4);
      MODE_AINC: sr_const = DATA_W'(8);
      default:   sr_const = '0;
    endcase
  end

  always_comb begin
    unique case (mode)
      MODE_REG:  cg_const = '0;
      MODE_IDX:  cg_const = DATA_W'(1);
      MODE_IND:  cg_const = DATA_W'(2);
      default:   cg_const = '1;
    endcase
  end

  assign hit = fn_is_const(reg_num, mode);

  always_comb begin
    value = '0;
    if (reg_num == CG_IDX)                  value = cg_const;
    else if (reg_num == SR_IDX && hit)      value = sr_const;
  end

endmodule

// File: rtl/opmode_src_dec.sv
module opmode_src_dec
  import opmode_pkg::*;
(
  input  logic [RIDX_W-1:0] reg_num,
  input  amode_e            mode,
  input  logic              is_byte,
  input  logic              cg_hit,
  output logic              mem_rd,
  output logic              ext,
  output logic              imm,
  output logic              sym,
  output logic              absl,
  output logic              inc_we,
  output logic [1:0]        inc_amt
);

  logic is_pc;
  assign is_pc  = (reg_num == PC_IDX);

  assign mem_rd = (mode != MODE_REG) && !cg_hit;
  assign ext    = fn_src_ext(reg_num, mode);
  assign imm    = is_pc && (mode == MODE_AINC);
  assign sym    = is_pc && (mode == MODE_IDX);
  assign absl   = (reg_num == SR_IDX) && (mode == MODE_IDX);
  assign inc_we = (mode == MODE_AINC) && !cg_hit;

  always_comb begin
    inc_amt = 2'd0;
    if (inc_we) inc_amt = fn_step(is_pc, is_byte);
  end

endmodule

// File: rtl/opmode_dst_dec.sv
module opmode_dst_dec
  import opmode_pkg::*;
(
  input  logic [RIDX_W-1:0] reg_num,
  input  logic              mode,
  output logic              mem_wr,
  output logic              ext,
  output logic              reg_we
);

  logic sink;
  assign sink   = (reg_num == CG_IDX);
  assign mem_wr = mode && !sink;
  assign ext    = mode && !sink;
  assign reg_we = !mode && !sink;

endmodule

// File: rtl/opmode_decoder.sv
module opmode_decoder
  import opmode_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        src_reg,
  input  logic [1:0]        src_mode,
  input  logic [3:0]        dst_reg,
  input  logic              dst_mode,
  input  logic              byte_op,
  output logic [1:0]        src_kind,
  output logic              src_mem_rd,
  output logic              src_ext,
  output logic              src_imm,
  output logic              src_sym,
  output logic              src_abs,
  output logic              const_vld,
  output logic [DATA_W-1:0] const_val,
  output logic              dst_kind,
  output logic              dst_mem_wr,
  output logic              dst_ext,
  output logic              dst_reg_we,
  output logic              inc_we,
  output logic [1:0]        inc_amt,
  output logic              addr_lsb_clr
);

  amode_e            s_mode;
  logic              cg_hit_w;
  logic [DATA_W-1:0] cg_val_w;
  logic              rd_w, ext_w, imm_w, sym_w, abs_w, inc_w;
  logic [1:0]        amt_w;
  logic              dwr_w, dext_w, dwe_w;
  logic              lsb_w;

  assign s_mode = amode_e'(src_mode);

  opmode_cg #(.DATA_W(DATA_W)) u_cg (
    .reg_num (src_reg),
    .mode    (s_mode),
    .hit     (cg_hit_w),
    .value   (cg_val_w)
  );

  opmode_src_dec u_src (
    .reg_num (src_reg),
    .mode    (s_mode),
    .is_byte (byte_op),
    .cg_hit  (cg_hit_w),
    .mem_rd  (rd_w),
    .ext     (ext_w),
    .imm     (imm_w),
    .sym     (sym_w),
    .absl    (abs_w),
    .inc_we  (inc_w),
    .inc_amt (amt_w)
  );

  opmode_dst_dec u_dst (
    .reg_num (dst_reg),
    .mode    (dst_mode),
    .mem_wr  (dwr_w),
    .ext     (dext_w),
    .reg_we  (dwe_w)
  );

  assign lsb_w = !byte_op && (rd_w || dwr_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_kind     <= 2'd0;
      src_mem_rd   <= 1'b0;
      src_ext      <= 1'b0;
      src_imm      <= 1'b0;
      src_sym      <= 1'b0;
      src_abs      <= 1'b0;
      const_vld    <= 1'b0;
      const_val    <= '0;
      dst_kind     <= 1'b0;
      dst_mem_wr   <= 1'b0;
      dst_ext      <= 1'b0;
      dst_reg_we   <= 1'b0;
      inc_we       <= 1'b0;
      inc_amt      <= 2'd0;
      addr_lsb_clr <= 1'b0;
    end else begin
      src_kind     <= src_mode;
      src_mem_rd   <= rd_w;
      src_ext      <= ext_w;
      src_imm      <= imm_w;
      src_sym      <= sym_w;
      src_abs      <= abs_w;
      const_vld    <= cg_hit_w;
      const_val    <= cg_val_w;
      dst_kind     <= dst_mode;
      dst_mem_wr   <= dwr_w;
      dst_ext      <= dext_w;
      dst_reg_we   <= dwe_w;
      inc_we       <= inc_w;
      inc_amt      <= amt_w;
      addr_lsb_clr <= lsb_w;
    end
  end

endmodule

// File: rtl/opmode_decoder_chk.sv
module opmode_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] src_reg,
  input logic [1:0] src_mode,
  input logic       dst_mode,
  input logic [1:0] src_kind,
  input logic       src_mem_rd,
  input logic       src_ext,
  input logic       const_vld,
  input logic       dst_kind,
  input logic       dst_mem_wr,
  input logic       dst_reg_we,
  input logic       inc_we,
  input logic [1:0] inc_amt,
  input logic       addr_lsb_clr
);

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R3
  src_kind_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    src_kind == $past(src_mode));

  // R2
  dst_kind_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    dst_kind == $past(dst_mode));

  // R4
  const_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    const_vld |-> (!src_mem_rd && !inc_we));

  // R6
  ext_source_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    src_ext |-> (($past(src_mode) == 2'd1 && $past(src_reg) != 4'd3) ||
                 ($past(src_mode) == 2'd3 && $past(src_reg) == 4'd0)));

  // R7
  inc_amt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_we |-> inc_amt == 2'd0);

  // R7
  inc_amt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_we |-> (inc_amt == 2'd1 || inc_amt == 2'd2));

  // R8
  dst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_reg_we && dst_mem_wr));

  // R9
  lsb_need_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_lsb_clr |-> (src_mem_rd || dst_mem_wr));

endmodule

bind opmode_decoder opmode_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_reg      (src_reg),
  .src_mode     (src_mode),
  .dst_mode     (dst_mode),
  .src_kind     (src_kind),
  .src_mem_rd   (src_mem_rd),
  .src_ext      (src_ext),
  .const_vld    (const_vld),
  .dst_kind     (dst_kind),
  .dst_mem_wr   (dst_mem_wr),
  .dst_reg_we   (dst_reg_we),
  .inc_we       (inc_we),
  .inc_amt      (inc_amt),
  .addr_lsb_clr (addr_lsb_clr)
);

// File: tb/opmode_decoder_bench.sv
`timescale 1ns/1ps
module opmode_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_reg = 4'd0;
  logic [1:0]  src_mode = 2'd0;
  logic [3:0]  dst_reg = 4'd0;
  logic        dst_mode = 1'b0;
  logic        byte_op = 1'b0;

  logic [1:0]  src_kind;
  logic        src_mem_rd, src_ext, src_imm, src_sym, src_abs, const_vld;
  logic [15:0] const_val;
  logic        dst_kind, dst_mem_wr, dst_ext, dst_reg_we, inc_we;
  logic [1:0]  inc_amt;
  logic        addr_lsb_clr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opmode_decoder u_opmode_decoder (
    .clk(clk), .rst_n(rst_n),
    .src_reg(src_reg), .src_mode(src_mode), .dst_reg(dst_reg),
    .dst_mode(dst_mode), .byte_op(byte_op),
    .src_kind(src_kind), .src_mem_rd(src_mem_rd), .src_ext(src_ext),
    .src_imm(src_imm), .src_sym(src_sym), .src_abs(src_abs),
    .const_vld(const_vld), .const_val(const_val),
    .dst_kind(dst_kind), .dst_mem_wr(dst_mem_wr), .dst_ext(dst_ext),
    .dst_reg_we(dst_reg_we), .inc_we(inc_we), .inc_amt(inc_amt),
    .addr_lsb_clr(addr_lsb_clr)
  );

  // Observed outputs packed in a fixed order (32 bits).
  function automatic logic [31:0] observed();
    return {src_kind, src_mem_rd, src_ext, src_imm, src_sym, src_abs,
            const_vld, const_val, dst_kind, dst_mem_wr, dst_ext, dst_reg_we,
            inc_we, inc_amt, addr_lsb_clr};
  endfunction

  // Reference decode written from the requirements.
  function automatic logic [31:0] model(input logic [3:0] r, input logic [1:0] m,
                                        input logic [3:0] d, input logic dm,
                                        input logic b);
    logic        k, rd, ex, im, sy, ab, iw, dw, dx, dr, lsb;
    logic [15:0] cv;
    logic [1:0]  ia;
    k  = 1'b0; cv = 16'h0000;
    if (r == 4'd3) begin
      k = 1'b1;
      case (m)
        2'd0: cv = 16'h0000;
        2'd1: cv = 16'h0001;
        2'd2: cv = 16'h0002;
        default: cv = 16'hFFFF;
      endcase
    end else if (r == 4'd2 && m == 2'd2) begin k = 1'b1; cv = 16'h0004; end
    else if (r == 4'd2 && m == 2'd3) begin k = 1'b1; cv = 16'h0008; end
    rd  = (m != 2'd0) && !k;
    ex  = (m == 2'd1 && r != 4'd3) || (m == 2'd3 && r == 4'd0);
    im  = (r == 4'd0) && (m == 2'd3);
    sy  = (r == 4'd0) && (m == 2'd1);
    ab  = (r == 4'd2) && (m == 2'd1);
    iw  = (m == 2'd3) && (r != 4'd2) && (r != 4'd3);
    ia  = !iw ? 2'd0 : ((r == 4'd0 || !b) ? 2'd2 : 2'd1);
    dw  = dm && (d != 4'd3);
    dx  = dw;
    dr  = !dm && (d != 4'd3);
    lsb = !b && (rd || dw);
    return {m, rd, ex, im, sy, ab, k, cv, dm, dw, dx, dr, iw, ia, lsb};
  endfunction

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic drive(input logic [3:0] r, input logic [1:0] m, input logic [3:0] d,
                       input logic dm, input logic b, input string tag);
    @(negedge clk);
    src_reg = r; src_mode = m; dst_reg = d; dst_mode = dm; byte_op = b;
    exp_q.push_back(model(r, m, d, dm, b));
    tag_q.push_back(tag);
  endtask

  // Monitor: one result due per rising edge after each drive.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        logic [31:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = observed();
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: nonzero fields during reset must not reach the outputs.
    src_reg = 4'd3; src_mode = 2'd3; dst_reg = 4'd5; dst_mode = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (observed() !== 32'h0) begin
      failures++;
      $display("FAIL R1 actual=%h expected=%h", observed(), 32'h0);
    end

    @(negedge clk);
    rst_n = 1'b1;

    // R4: every constant combination.
    drive(4'd2, 2'd2, 4'd4, 1'b0, 1'b0, "R4");
    drive(4'd2, 2'd3, 4'd4, 1'b0, 1'b0, "R4");
    drive(4'd3, 2'd0, 4'd4, 1'b1, 1'b0, "R4");
    drive(4'd3, 2'd1, 4'd4, 1'b1, 1'b1, "R4");
    drive(4'd3, 2'd2, 4'd4, 1'b0, 1'b1, "R4");
    drive(4'd3, 2'd3, 4'd4, 1'b0, 1'b0, "R4");
    // R6: immediate, symbolic, absolute.
    drive(4'd0, 2'd3, 4'd6, 1'b0, 1'b1, "R6");
    drive(4'd0, 2'd1, 4'd6, 1'b1, 1'b0, "R6");
    drive(4'd2, 2'd1, 4'd6, 1'b1, 1'b0, "R6");
    // R7: byte vs word steps, PC always 2.
    drive(4'd7, 2'd3, 4'd1, 1'b0, 1'b1, "R7");
    drive(4'd7, 2'd3, 4'd1, 1'b0, 1'b0, "R7");
    drive(4'd0, 2'd3, 4'd1, 1'b0, 1'b1, "R7");
    // R8: destination sink, status register, memory.
    drive(4'd5, 2'd0, 4'd3, 1'b0, 1'b0, "R8");
    drive(4'd5, 2'd0, 4'd3, 1'b1, 1'b0, "R8");
    drive(4'd5, 2'd0, 4'd2, 1'b0, 1'b0, "R8");
    drive(4'd5, 2'd0, 4'd2, 1'b1, 1'b0, "R8");
    // R9: alignment flag follows operand size and access.
    drive(4'd5, 2'd2, 4'd9, 1'b0, 1'b0, "R9");
    drive(4'd5, 2'd2, 4'd9, 1'b0, 1'b1, "R9");
    drive(4'd5, 2'd0, 4'd9, 1'b1, 1'b0, "R9");
    drive(4'd5, 2'd0, 4'd9, 1'b0, 1'b0, "R9");
    // R2: back-to-back alternation every cycle.
    for (int i = 0; i < 8; i++)
      drive(4'(i * 3), 2'(i), 4'(15 - i), 1'(i), 1'(i >> 1), "R2");
    // R3 / R5: sweep every source register and mode.
    for (int r = 0; r < 16; r++) begin
      for (int m = 0; m < 4; m++) begin
        drive(4'(r), 2'(m), 4'((r * 5 + m) % 16), 1'(r ^ m), 1'((r + m) >> 1), m == 0 ? "R3" : "R5");
      end
    end

    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule